// File: doc/BRIEF.md
# Priority Ring Preemption Controller

This block decides which of several command rings a command processor works on, and it runs the hand-over when a more urgent ring has work. Each ring reports whether it holds pending work. A submit strobe or a completion strobe makes the controller look at those flags again. If the most urgent non-empty ring is not the one running, the controller holds a switch request open. It waits until a boundary allowed by the configured preemption level, and in level 1 by the rendering mode, arrives.

Once the boundary arrives, the controller takes the ring through a fixed handshake: it asks for the running ring's state to be saved, then asks for the target ring's state to be restored, then signals resume for one cycle, and then raises a one-cycle switch-complete interrupt. When the save/restore skip option is set, the controller marks the handshake as a reduced save, but only in tiled mode at level 1. Strobes that arrive while a switch is under way are remembered and evaluated as soon as the controller is idle again.

Top module: `ring_preempt_ctrl`

## Requirements
- R1: After reset, cur_ring is NRINGS-1 (the lowest-priority ring), switch_busy is 0, and save_req, restore_req, resume, switch_irq and reduced_save are all 0.
- R2: Ring index 0 has the highest priority, and larger indices are less urgent. On a submit_evt or complete_evt seen while idle, the target is the lowest-index ring whose ring_has_work bit is 1. That target is shown on tgt_ring, and switch_busy rises in the next cycle.
- R3: When the chosen ring equals cur_ring, no switch starts: switch_busy stays 0 and cur_ring does not change.
- R4: When no ring_has_work bit is set, an event starts no switch and cur_ring does not change.
- R5: With cfg_level = 0, a pending switch leaves its wait only on bnd_submit. bnd_bin and bnd_draw have no effect.
- R6: With cfg_level = 1, a pending switch leaves its wait on bnd_bin when cfg_tiled = 1, and on bnd_draw when cfg_tiled = 0. The other of those two strobes is ignored.
- R7: With cfg_level = 2 (3 behaves the same), a pending switch leaves its wait only on bnd_draw.
- R8: Once a boundary is accepted, save_req is held high until save_done. Then restore_req is held high until restore_done. In the cycle after restore_done, resume is high for one cycle and cur_ring equals the target. switch_irq is high for the one cycle after that, and the controller then returns to idle.
- R9: reduced_save is high during save_req and restore_req exactly when cfg_skip_sr = 1, cfg_tiled = 1 and cfg_level = 1, sampled when the boundary is accepted. At all other times it is 0.
- R10: A submit_evt or complete_evt that arrives while switch_busy is 1 is stored. It is evaluated in the first idle cycle, which can start a new switch in the next cycle.
- R11: At most one of save_req, restore_req, resume and switch_irq is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_has_work | input | NRINGS | Per-ring non-empty flag, bit 0 most urgent |
| submit_evt | input | 1 | Work was submitted to some ring |
| complete_evt | input | 1 | A submission has finished |
| bnd_submit | input | 1 | Execution is at a submission boundary |
| bnd_bin | input | 1 | Execution is at a bin boundary |
| bnd_draw | input | 1 | Execution is at a draw boundary |
| cfg_level | input | 2 | Preemption level 0, 1 or 2 (3 acts as 2) |
| cfg_tiled | input | 1 | 1 = tiled on-chip rendering, 0 = direct rendering |
| cfg_skip_sr | input | 1 | Request a reduced save/restore |
| save_done | input | 1 | Save of current ring finished |
| restore_done | input | 1 | Restore of target ring finished |
| save_req | output | 1 | Save current ring's state |
| restore_req | output | 1 | Restore target ring's state |
| resume | output | 1 | One-cycle resume pulse |
| switch_irq | output | 1 | One-cycle switch-complete interrupt |
| reduced_save | output | 1 | Handshake covers only core-control state |
| switch_busy | output | 1 | A switch is pending or in progress |
| cur_ring | output | RIDX_W | Ring currently executing |
| tgt_ring | output | RIDX_W | Ring the controller is switching to |

## Verification
Some properties are checked on every cycle. The four handshake outputs are mutually exclusive. Resume follows only an acknowledged restore, and the interrupt follows only resume. cur_ring changes only on entry to resume. reduced_save never shows outside a save or restore. The boundary gate never lets a wait end on a strobe its level forbids. The picker's choice always names a ring that has work. Other behaviour can only be shown by the directed scenarios, because it depends on earlier stimulus: which ring is picked for a given pattern, that ignored strobes really leave the wait in place, the reduced-save qualification in each mode, and the replay of an event that arrived during a switch.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_WAIT    = 3'd1,
        ST_SAVE    = 3'd2,
        ST_RESTORE = 3'd3,
        ST_RESUME  = 3'd4,
        ST_DONE    = 3'd5
    } rpc_state_e;

    typedef enum logic [1:0] {
        LVL_SUBMIT = 2'd0,
        LVL_BIN    = 2'd1,
        LVL_DRAW   = 2'd2,
        LVL_DRAW_X = 2'd3
    } rpc_level_e;

endpackage

// File: rtl/rpc_prio_pick.sv
module rpc_prio_pick #(
    parameter int NRINGS = 4,
    localparam int RIDX_W = (NRINGS > 1) ? $clog2(NRINGS) : 1
) (
    input  logic [NRINGS-1:0] busy,
    output logic              found,
    output logic [RIDX_W-1:0] pick
);

    // scan from the least urgent ring down so the lowest index wins
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NRINGS - 1; i >= 0; i--) begin
            if (busy[i]) begin
                found = 1'b1;
                pick  = RIDX_W'(i);
            end
        end
    end

    // R2
    always_comb begin
        if (found) begin
            pick_has_work_chk: assert (busy[pick]);
        end
    end

endmodule

// File: rtl/rpc_bnd_gate.sv
module rpc_bnd_gate
    import rpc_pkg::*;
(
    input  logic [1:0] level,
    input  logic       tiled,
    input  logic       skip_sr,
    input  logic       at_submit,
    input  logic       at_bin,
    input  logic       at_draw,
    output logic       permit,
    output logic       reduced
);

    rpc_level_e lvl;

    always_comb begin
        lvl = rpc_level_e'(level);
        unique case (lvl)
            LVL_SUBMIT: permit = at_submit;
            LVL_BIN:    permit = tiled ? at_bin : at_draw;
            default:    permit = at_draw;
        endcase
        reduced = skip_sr && tiled && (lvl == LVL_BIN);
    end

    // R5
    always_comb begin
        if (permit && level == 2'd0) begin
            lvl0_only_submit_chk: assert (at_submit);
        end
    end

    // R7
    always_comb begin
        if (permit && level[1]) begin
            lvl2_only_draw_chk: assert (at_draw);
        end
    end

endmodule

// File: rtl/ring_preempt_ctrl.sv
module ring_preempt_ctrl
    import rpc_pkg::*;
#(
    parameter int NRINGS = 4,
    localparam int RIDX_W = (NRINGS > 1) ? $clog2(NRINGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NRINGS-1:0] ring_has_work,
    input  logic              submit_evt,
    input  logic              complete_evt,
    input  logic              bnd_submit,
    input  logic              bnd_bin,
    input  logic              bnd_draw,
    input  logic [1:0]        cfg_level,
    input  logic              cfg_tiled,
    input  logic              cfg_skip_sr,
    input  logic              save_done,
    input  logic              restore_done,
    output logic              save_req,
    output logic              restore_req,
    output logic              resume,
    output logic              switch_irq,
    output logic              reduced_save,
    output logic              switch_busy,
    output logic [RIDX_W-1:0] cur_ring,
    output logic [RIDX_W-1:0] tgt_ring
);

    localparam logic [RIDX_W-1:0] IDLE_RING = RIDX_W'(NRINGS - 1);

    typedef struct packed {
        rpc_state_e        state;
        logic [RIDX_W-1:0] cur;
        logic [RIDX_W-1:0] tgt;
        logic              pend;
        logic              reduced;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              pick_found;
    logic [RIDX_W-1:0] pick_idx;
    logic              gate_permit;
    logic              gate_reduced;
    logic              evt_now;

    rpc_prio_pick #(.NRINGS(NRINGS)) u_pick (
        .busy  (ring_has_work),
        .found (pick_found),
        .pick  (pick_idx)
    );

    rpc_bnd_gate u_gate (
        .level     (cfg_level),
        .tiled     (cfg_tiled),
        .skip_sr   (cfg_skip_sr),
        .at_submit (bnd_submit),
        .at_bin    (bnd_bin),
        .at_draw   (bnd_draw),
        .permit    (gate_permit),
        .reduced   (gate_reduced)
    );

    assign evt_now = submit_evt || complete_evt;

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.state != ST_IDLE && evt_now) begin
            ctl_d.pend = 1'b1;
        end
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (evt_now || ctl_q.pend) begin
                    ctl_d.pend = 1'b0;
                    if (pick_found && pick_idx != ctl_q.cur) begin
                        ctl_d.tgt   = pick_idx;
                        ctl_d.state = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (gate_permit) begin
                    ctl_d.reduced = gate_reduced;
                    ctl_d.state   = ST_SAVE;
                end
            end
            ST_SAVE: begin
                if (save_done) begin
                    ctl_d.state = ST_RESTORE;
                end
            end
            ST_RESTORE: begin
                if (restore_done) begin
                    ctl_d.cur     = ctl_q.tgt;
                    ctl_d.reduced = 1'b0;
                    ctl_d.state   = ST_RESUME;
                end
            end
            ST_RESUME: begin
                ctl_d.state = ST_DONE;
            end
            ST_DONE: begin
                ctl_d.state = ST_IDLE;
            end
            default: begin
                ctl_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.state   <= ST_IDLE;
            ctl_q.cur     <= IDLE_RING;
            ctl_q.tgt     <= IDLE_RING;
            ctl_q.pend    <= 1'b0;
            ctl_q.reduced <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign save_req     = (ctl_q.state == ST_SAVE);
    assign restore_req  = (ctl_q.state == ST_RESTORE);
    assign resume       = (ctl_q.state == ST_RESUME);
    assign switch_irq   = (ctl_q.state == ST_DONE);
    assign reduced_save = ctl_q.reduced;
    assign switch_busy  = (ctl_q.state != ST_IDLE);
    assign cur_ring     = ctl_q.cur;
    assign tgt_ring     = ctl_q.tgt;

    // R11
    handshake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({save_req, restore_req, resume, switch_irq}));

    // R8
    resume_after_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume) |-> $past(restore_req && restore_done));

    // R8
    irq_after_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        switch_irq |-> $past(resume));

    // R8
    restore_after_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restore_req) |-> $past(save_req && save_done));

    // R3
    cur_moves_on_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_ring) |-> resume);

    // R9
    reduced_in_handshake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reduced_save |-> (save_req || restore_req));

endmodule

// File: tb/tb_ring_preempt_ctrl.sv
module tb_ring_preempt_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] ring_has_work = '0;
    logic          submit_evt = 1'b0, complete_evt = 1'b0;
    logic          bnd_submit = 1'b0, bnd_bin = 1'b0, bnd_draw = 1'b0;
    logic [1:0]    cfg_level = 2'd0;
    logic          cfg_tiled = 1'b0, cfg_skip_sr = 1'b0;
    logic          save_done = 1'b0, restore_done = 1'b0;
    logic          save_req, restore_req, resume, switch_irq, reduced_save, switch_busy;
    logic [1:0]    cur_ring, tgt_ring;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    ring_preempt_ctrl #(.NRINGS(NR)) dut (
        .clk(clk), .rst_n(rst_n), .ring_has_work(ring_has_work),
        .submit_evt(submit_evt), .complete_evt(complete_evt),
        .bnd_submit(bnd_submit), .bnd_bin(bnd_bin), .bnd_draw(bnd_draw),
        .cfg_level(cfg_level), .cfg_tiled(cfg_tiled), .cfg_skip_sr(cfg_skip_sr),
        .save_done(save_done), .restore_done(restore_done),
        .save_req(save_req), .restore_req(restore_req), .resume(resume),
        .switch_irq(switch_irq), .reduced_save(reduced_save),
        .switch_busy(switch_busy), .cur_ring(cur_ring), .tgt_ring(tgt_ring)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_submit();
        submit_evt = 1'b1; tick(); submit_evt = 1'b0;
    endtask

    task automatic pulse_complete();
        complete_evt = 1'b1; tick(); complete_evt = 1'b0;
    endtask

    // drive a strobe for one cycle while waiting; expect no progress
    task automatic strobe_ignored(string req, int which);
        bnd_submit = (which == 0); bnd_bin = (which == 1); bnd_draw = (which == 2);
        tick();
        bnd_submit = 0; bnd_bin = 0; bnd_draw = 0;
        check(req, save_req, 0);
        check(req, switch_busy, 1);
    endtask

    // accept boundary and run the full handshake to ring exp_tgt
    task automatic run_switch(string req, int which, int exp_tgt, int exp_red);
        bnd_submit = (which == 0); bnd_bin = (which == 1); bnd_draw = (which == 2);
        tick();
        bnd_submit = 0; bnd_bin = 0; bnd_draw = 0;
        check({req, " save_req"}, save_req, 1);
        check("R9 reduced in save", reduced_save, exp_red);
        tick();
        check("R8 save held", save_req, 1);
        save_done = 1; tick(); save_done = 0;
        check("R8 restore_req", restore_req, 1);
        check("R11 save dropped", save_req, 0);
        check("R9 reduced in restore", reduced_save, exp_red);
        tick();
        check("R8 restore held", restore_req, 1);
        restore_done = 1; tick(); restore_done = 0;
        check("R8 resume", resume, 1);
        check("R8 cur=tgt", cur_ring, exp_tgt);
        check("R11 irq not with resume", switch_irq, 0);
        check("R9 reduced cleared", reduced_save, 0);
        tick();
        check("R8 irq", switch_irq, 1);
        check("R11 resume low", resume, 0);
        tick();
        check("R8 irq one cycle", switch_irq, 0);
        check("R8 idle", switch_busy, 0);
    endtask

    task automatic t_reset();
        check("R1 cur", cur_ring, 3);
        check("R1 busy", switch_busy, 0);
        check("R1 hs", {save_req, restore_req, resume, switch_irq, reduced_save}, 0);
    endtask

    task automatic t_empty();
        ring_has_work = 4'b0000;
        pulse_submit();
        check("R4 no switch", switch_busy, 0);
        check("R4 cur kept", cur_ring, 3);
    endtask

    task automatic t_same();
        ring_has_work = 4'b1000;
        pulse_complete();
        check("R3 no switch", switch_busy, 0);
        check("R3 cur kept", cur_ring, 3);
    endtask

    task automatic t_level0();
        cfg_level = 2'd0; cfg_tiled = 1; cfg_skip_sr = 1;
        ring_has_work = 4'b1010;
        pulse_submit();
        check("R2 busy", switch_busy, 1);
        check("R2 tgt", tgt_ring, 1);
        strobe_ignored("R5 draw ignored", 2);
        strobe_ignored("R5 bin ignored", 1);
        run_switch("R5", 0, 1, 0);
    endtask

    task automatic t_level1_tiled();
        cfg_level = 2'd1; cfg_tiled = 1; cfg_skip_sr = 1;
        ring_has_work = 4'b1011;
        pulse_submit();
        check("R2 tgt highest", tgt_ring, 0);
        strobe_ignored("R6 draw ignored tiled", 2);
        strobe_ignored("R6 submit ignored", 0);
        run_switch("R6 tiled", 1, 0, 1);
    endtask

    task automatic t_level1_direct();
        cfg_level = 2'd1; cfg_tiled = 0; cfg_skip_sr = 1;
        ring_has_work = 4'b0100;
        pulse_complete();
        check("R2 tgt after complete", tgt_ring, 2);
        strobe_ignored("R6 bin ignored direct", 1);
        run_switch("R6 direct", 2, 2, 0);
    endtask

    task automatic t_level2_latch();
        cfg_level = 2'd2; cfg_tiled = 1; cfg_skip_sr = 1;
        ring_has_work = 4'b0010;
        pulse_submit();
        check("R2 tgt", tgt_ring, 1);
        strobe_ignored("R7 bin ignored", 1);
        strobe_ignored("R7 submit ignored", 0);
        bnd_draw = 1; tick(); bnd_draw = 0;
        check("R7 save_req", save_req, 1);
        check("R9 no reduce at lvl2", reduced_save, 0);
        ring_has_work = 4'b0011;
        pulse_submit();
        check("R10 tgt held during switch", tgt_ring, 1);
        save_done = 1; tick(); save_done = 0;
        restore_done = 1; tick(); restore_done = 0;
        check("R8 resume", resume, 1);
        check("R8 cur", cur_ring, 1);
        tick();
        check("R8 irq", switch_irq, 1);
        tick();
        check("R10 idle cycle", switch_busy, 0);
        tick();
        check("R10 replayed busy", switch_busy, 1);
        check("R10 replayed tgt", tgt_ring, 0);
        run_switch("R7", 2, 0, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_empty();
        t_same();
        t_level0();
        t_level1_tiled();
        t_level1_direct();
        t_level2_latch();
        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule